// File: doc/BRIEF.md
# Gated Exposure Window Sequencer

This block drives the three global shutter controls of a photon-counting pixel array. The first is a detector-off level that removes bias. The second is a recharge pulse that restores bias. The third is a memory gate that lets photon events into the pixel memory. All three come from one clock that is locked to the illumination reference, so every edge falls on that clock's grid. Each pattern opens one short sensitivity window. The window opens when recharge restores bias and closes when the gate drops.

Edge positions are given in clock cycles, counted from the start of each pattern. A new setting is taken only when a pattern starts. A setting that would let the gate overlap the off level or the recharge pulse is refused, and the previous setting stays in use. After each pattern the block pulses `done`, and the readout controller can hold off the next pattern with `rd_busy`. A position index selects the sub-cycle phase of the pattern relative to the reference. In scan mode the index advances by one after a programmable number of patterns, and it wraps to zero at the end of the reference period.

Top module: `gate_window_seq`

## Requirements
- R1: While reset is held and straight after it is released, `off`=1 and `rch`=0, `gate`=0, `done`=0, `pos`=0, `scan_wrap`=0.
- R2: A pattern counts cycles t=0,1,…,period-1 from its launch. During a pattern, `off` is 1 when t<off_fall or t>gate_fall and 0 otherwise. Whenever no pattern runs, `off` is 1 and the other two controls are 0.
- R3: `rch` is 1 exactly for off_fall ≤ t < rch_fall.
- R4: `gate` is 1 exactly for gate_rise ≤ t < gate_fall. It is never 1 together with `off` or with `rch`.
- R5: `done` is 1 for exactly one cycle, at t=period-1 of each pattern.
- R6: A setting is accepted only if 1 ≤ off_fall < rch_fall ≤ gate_rise < gate_fall and gate_fall+2 ≤ period. Otherwise the setting is ignored and the last accepted one stays in use.
- R7: The five timing inputs are sampled only at the clock edge that launches a pattern. Changes made during a pattern do not affect that pattern.
- R8: With `scan_en`=1, each `done` counts one readout. After max(cfg_reads,1) readouts at a position, `pos` is one higher in the following cycle and the readout count clears.
- R9: A pattern is launched, back to back after `done` or from idle, at any edge where `en`=1 and `rd_busy`=0. Otherwise the block stays idle.
- R10: In scan mode, stepping from position NPOS-1 gives `pos`=0 and a one-cycle `scan_wrap` pulse in that same cycle.
- R11: With `scan_en`=0, each `done` clears the readout count. It also loads `cfg_offset` into `pos` if cfg_offset < NPOS, and otherwise leaves `pos` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock locked to the reference |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Allows patterns to be launched |
| rd_busy | input | 1 | Readout in progress; holds off the next launch |
| scan_en | input | 1 | Selects scan mode for the position index |
| cfg_period | input | T_W | Pattern length in cycles |
| cfg_off_fall | input | T_W | Cycle at which the off level drops and recharge begins |
| cfg_rch_fall | input | T_W | Cycle at which recharge ends |
| cfg_gate_rise | input | T_W | Cycle at which the gate opens |
| cfg_gate_fall | input | T_W | Cycle at which the gate closes; off returns one cycle later |
| cfg_reads | input | RD_W | Readouts per scan position (0 is treated as 1) |
| cfg_offset | input | POS_W | Fixed position index used when not scanning |
| off | output | 1 | Detector-off control |
| rch | output | 1 | Recharge pulse |
| gate | output | 1 | Memory gate |
| done | output | 1 | Last cycle of a pattern |
| pos | output | POS_W | Sub-cycle phase position index |
| scan_wrap | output | 1 | Scan returned to position 0 |

## Verification
A wrong cycle counter or a corrupted shadow setting moves a control edge. The per-cycle comparison against the bench model catches this within one pattern, and no later than the next `done`. A readout count or position register that drifts shows on `pos` in the cycle after the `done` that should have stepped it. A missed wrap shows on `scan_wrap` in that same cycle. A setting taken mid-pattern, or an invalid setting that was accepted, displaces an edge in the same pattern or the next one.

// File: rtl/gws_pkg.sv
package gws_pkg;
  // Legality of a window setting: ordered edges, gate clear of recharge,
  // and room for the off level to return before the pattern ends.
  function automatic logic win_ok(input int unsigned per, input int unsigned of_c,
                                  input int unsigned rf, input int unsigned gr,
                                  input int unsigned gf);
    return (of_c >= 1) && (of_c < rf) && (rf <= gr) && (gr < gf) && (gf + 2 <= per);
  endfunction

  // Number of readouts per position; zero is taken as one.
  function automatic int unsigned reads_eff(input int unsigned r);
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/gws_timer.sv
module gws_timer #(
  parameter int T_W     = 8,
  parameter int DEF_PER = 20,
  parameter int DEF_OF  = 2,
  parameter int DEF_RF  = 4,
  parameter int DEF_GR  = 5,
  parameter int DEF_GF  = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [T_W-1:0] c_per,
  input  logic [T_W-1:0] c_of,
  input  logic [T_W-1:0] c_rf,
  input  logic [T_W-1:0] c_gr,
  input  logic [T_W-1:0] c_gf,
  output logic           run,
  output logic [T_W-1:0] t,
  output logic [T_W-1:0] sh_per,
  output logic [T_W-1:0] sh_of,
  output logic [T_W-1:0] sh_rf,
  output logic [T_W-1:0] sh_gr,
  output logic [T_W-1:0] sh_gf,
  output logic           pat_end,
  output logic           launch,
  output logic           cfg_reject
);
  import gws_pkg::*;

  logic cfg_good;

  assign cfg_good   = win_ok(int'(c_per), int'(c_of), int'(c_rf), int'(c_gr), int'(c_gf));
  assign pat_end    = run && (t == sh_per - 1'b1);
  assign launch     = (!run || pat_end) && go;
  assign cfg_reject = launch && !cfg_good;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      t      <= '0;
      sh_per <= T_W'(DEF_PER);
      sh_of  <= T_W'(DEF_OF);
      sh_rf  <= T_W'(DEF_RF);
      sh_gr  <= T_W'(DEF_GR);
      sh_gf  <= T_W'(DEF_GF);
    end else if (!run || pat_end) begin
      t <= '0;
      if (go) begin
        run <= 1'b1;
        if (cfg_good) begin
          sh_per <= c_per;
          sh_of  <= c_of;
          sh_rf  <= c_rf;
          sh_gr  <= c_gr;
          sh_gf  <= c_gf;
        end
      end else begin
        run <= 1'b0;
      end
    end else begin
      t <= t + 1'b1;
    end
  end
endmodule

// File: rtl/gws_pattern.sv
module gws_pattern #(
  parameter int T_W = 8
) (
  input  logic           run,
  input  logic [T_W-1:0] t,
  input  logic [T_W-1:0] sh_of,
  input  logic [T_W-1:0] sh_rf,
  input  logic [T_W-1:0] sh_gr,
  input  logic [T_W-1:0] sh_gf,
  output logic           off,
  output logic           rch,
  output logic           gate
);
  always_comb begin
    off  = !run || (t < sh_of) || (t > sh_gf);
    rch  = run && (t >= sh_of) && (t < sh_rf);
    gate = run && (t >= sh_gr) && (t < sh_gf);
  end
endmodule

// File: rtl/gws_scan.sv
module gws_scan #(
  parameter int NPOS  = 1280,
  parameter int RD_W  = 8,
  localparam int POS_W = $clog2(NPOS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_end,
  input  logic             scan_en,
  input  logic [RD_W-1:0]  cfg_reads,
  input  logic [POS_W-1:0] cfg_offset,
  output logic [POS_W-1:0] pos,
  output logic             wrap,
  output logic             step
);
  import gws_pkg::*;

  logic [RD_W-1:0] rd_cnt;
  logic [RD_W:0]   nxt_cnt;
  logic            at_last;
  logic            ofs_ok;

  assign nxt_cnt = {1'b0, rd_cnt} + 1'b1;
  assign step    = pat_end && scan_en && (int'(nxt_cnt) >= int'(reads_eff(int'(cfg_reads))));
  assign at_last = (int'(pos) == NPOS - 1);
  assign ofs_ok  = (int'(cfg_offset) < NPOS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      rd_cnt <= '0;
      wrap   <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (pat_end) begin
        if (!scan_en) begin
          rd_cnt <= '0;
          if (ofs_ok) pos <= cfg_offset;
        end else if (step) begin
          rd_cnt <= '0;
          if (at_last) begin
            pos  <= '0;
            wrap <= 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end else begin
          rd_cnt <= nxt_cnt[RD_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/gate_window_seq.sv
module gate_window_seq #(
  parameter int T_W     = 8,
  parameter int RD_W    = 8,
  parameter int NPOS    = 1280,
  parameter int DEF_PER = 20,
  parameter int DEF_OF  = 2,
  parameter int DEF_RF  = 4,
  parameter int DEF_GR  = 5,
  parameter int DEF_GF  = 9,
  localparam int POS_W  = $clog2(NPOS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rd_busy,
  input  logic             scan_en,
  input  logic [T_W-1:0]   cfg_period,
  input  logic [T_W-1:0]   cfg_off_fall,
  input  logic [T_W-1:0]   cfg_rch_fall,
  input  logic [T_W-1:0]   cfg_gate_rise,
  input  logic [T_W-1:0]   cfg_gate_fall,
  input  logic [RD_W-1:0]  cfg_reads,
  input  logic [POS_W-1:0] cfg_offset,
  output logic             off,
  output logic             rch,
  output logic             gate,
  output logic             done,
  output logic [POS_W-1:0] pos,
  output logic             scan_wrap
);
  // Internal events, named for the checker.
  logic           run;
  logic [T_W-1:0] t;
  logic [T_W-1:0] sh_per, sh_of, sh_rf, sh_gr, sh_gf;
  logic           pat_end, launch, cfg_reject, pos_step;

  gws_timer #(
    .T_W(T_W), .DEF_PER(DEF_PER), .DEF_OF(DEF_OF), .DEF_RF(DEF_RF),
    .DEF_GR(DEF_GR), .DEF_GF(DEF_GF)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .go(en && !rd_busy),
    .c_per(cfg_period), .c_of(cfg_off_fall), .c_rf(cfg_rch_fall),
    .c_gr(cfg_gate_rise), .c_gf(cfg_gate_fall),
    .run(run), .t(t),
    .sh_per(sh_per), .sh_of(sh_of), .sh_rf(sh_rf), .sh_gr(sh_gr), .sh_gf(sh_gf),
    .pat_end(pat_end), .launch(launch), .cfg_reject(cfg_reject)
  );

  gws_pattern #(.T_W(T_W)) u_pattern (
    .run(run), .t(t), .sh_of(sh_of), .sh_rf(sh_rf), .sh_gr(sh_gr), .sh_gf(sh_gf),
    .off(off), .rch(rch), .gate(gate)
  );

  gws_scan #(.NPOS(NPOS), .RD_W(RD_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .pat_end(pat_end), .scan_en(scan_en),
    .cfg_reads(cfg_reads), .cfg_offset(cfg_offset),
    .pos(pos), .wrap(scan_wrap), .step(pos_step)
  );

  assign done = pat_end;
endmodule

// File: rtl/gws_checker.sv
module gws_checker #(
  parameter int NPOS  = 1280,
  parameter int T_W   = 8,
  localparam int POS_W = $clog2(NPOS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             off,
  input logic             rch,
  input logic             gate,
  input logic             done,
  input logic             rd_busy,
  input logic [POS_W-1:0] pos,
  input logic             wrap,
  input logic             cfg_reject,
  input logic [T_W-1:0]   sh_gr
);
  assert_gate_offlow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> !off);
  assert_gate_rch_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> !rch);
  assert_rch_on_offfall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(off) |-> rch);
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_busy) |=> (off && !rch && !gate));
  assert_pos_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos) < NPOS);
  assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (pos == '0));
  assert_reject_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |=> $stable(sh_gr));
endmodule

bind gate_window_seq gws_checker #(.NPOS(NPOS), .T_W(T_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .off(off), .rch(rch), .gate(gate), .done(done),
  .rd_busy(rd_busy), .pos(pos), .wrap(scan_wrap), .cfg_reject(cfg_reject),
  .sh_gr(sh_gr)
);

// File: tb/tb_gate_window_seq.sv
`timescale 1ns/1ps
module tb_gate_window_seq;
  localparam int T_W = 8, RD_W = 8, NPOS = 12, POS_W = $clog2(NPOS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, rd_busy = 0, scan_en = 0;
  logic [T_W-1:0] c_per = 20, c_of = 2, c_rf = 4, c_gr = 5, c_gf = 9;
  logic [RD_W-1:0] c_reads = 2;
  logic [POS_W-1:0] c_ofs = 0;
  logic off, rch, gate, done, scan_wrap;
  logic [POS_W-1:0] pos;

  always #2.5 clk = ~clk;

  gate_window_seq #(.T_W(T_W), .RD_W(RD_W), .NPOS(NPOS)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rd_busy(rd_busy), .scan_en(scan_en),
    .cfg_period(c_per), .cfg_off_fall(c_of), .cfg_rch_fall(c_rf),
    .cfg_gate_rise(c_gr), .cfg_gate_fall(c_gf), .cfg_reads(c_reads),
    .cfg_offset(c_ofs), .off(off), .rch(rch), .gate(gate), .done(done),
    .pos(pos), .scan_wrap(scan_wrap));

  int checks = 0, failures = 0, wraps_seen = 0;
  string phase = "R2";
  bit finished = 0;

  // Behavioural reference model.
  bit m_run = 0, m_wrap = 0, fin;
  int m_t = 0, m_pos = 0, m_cnt = 0;
  int s_per = 20, s_of = 2, s_rf = 4, s_gr = 5, s_gf = 9;

  function automatic bit legal(int p, int a, int b, int g1, int g2);
    return (g2 + 2 <= p) && (g1 < g2) && (b <= g1) && (a < b) && (a > 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_t = 0; m_pos = 0; m_cnt = 0; m_wrap = 0;
      s_per = 20; s_of = 2; s_rf = 4; s_gr = 5; s_gf = 9;
    end else begin
      fin = m_run && (m_t == s_per - 1);
      m_wrap = 0;
      if (fin) begin
        if (scan_en) begin
          m_cnt++;
          if (m_cnt >= ((c_reads == 0) ? 1 : int'(c_reads))) begin
            m_cnt = 0;
            if (m_pos == NPOS - 1) begin m_pos = 0; m_wrap = 1; end
            else m_pos++;
          end
        end else begin
          m_cnt = 0;
          if (int'(c_ofs) < NPOS) m_pos = int'(c_ofs);
        end
      end
      if (m_run && !fin) m_t++;
      else if (en && !rd_busy) begin
        m_run = 1; m_t = 0;
        if (legal(c_per, c_of, c_rf, c_gr, c_gf)) begin
          s_per = c_per; s_of = c_of; s_rf = c_rf; s_gr = c_gr; s_gf = c_gf;
        end
      end else begin
        m_run = 0; m_t = 0;
      end
    end
  end

  task automatic chk(string req, string sig, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s (phase %s) %s act=%0d exp=%0d t=%0t", req, phase, sig, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", "off",  off,  (!m_run || m_t < s_of || m_t > s_gf) ? 1 : 0);
      chk("R3", "rch",  rch,  (m_run && m_t >= s_of && m_t < s_rf) ? 1 : 0);
      chk("R4", "gate", gate, (m_run && m_t >= s_gr && m_t < s_gf) ? 1 : 0);
      chk("R5", "done", done, (m_run && m_t == s_per - 1) ? 1 : 0);
      chk("R8", "pos",  int'(pos), m_pos);
      chk("R10", "scan_wrap", scan_wrap, m_wrap);
      if (scan_wrap) wraps_seen++;
    end
  end

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired act=1 exp=0");
      report();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state, during and right after reset.
    cyc(3);
    phase = "R1";
    chk("R1", "off", off, 1); chk("R1", "gate", gate, 0); chk("R1", "rch", rch, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "done", done, 0); chk("R1", "pos", int'(pos), 0);
    chk("R1", "scan_wrap", scan_wrap, 0); chk("R1", "off_idle", off, 1);

    // R2 R3 R4 R5: default patterns back to back (R9 launch).
    phase = "R2"; en = 1; cyc(70);

    // R7: valid change in mid-pattern; takes effect only at the next launch.
    phase = "R7"; cyc(7); c_per = 16; c_of = 3; c_rf = 6; c_gr = 7; c_gf = 12; cyc(60);

    // R6: illegal settings (gate overlapping recharge, then no room for off) ignored.
    phase = "R6"; c_gr = 5; cyc(40); c_gr = 7; c_gf = 15; cyc(40);
    c_gf = 14; c_per = 16; cyc(40);
    c_of = 0; cyc(40); c_of = 3;
    // Short window: one-cycle gate.
    c_per = 10; c_of = 1; c_rf = 2; c_gr = 2; c_gf = 3; cyc(40);

    // R9: readout interlock and enable.
    phase = "R9"; rd_busy = 1; cyc(30); rd_busy = 0; cyc(25);
    en = 0; cyc(20); en = 1; cyc(3); rd_busy = 1; cyc(15); rd_busy = 0; cyc(30);

    // R8 R10: scan with two readouts per position, wraps at least twice.
    phase = "R10"; c_per = 20; c_of = 2; c_rf = 4; c_gr = 5; c_gf = 9;
    scan_en = 1; c_reads = 2; wraps_seen = 0; cyc(1100);
    chk("R10", "wrap_count_ge2", (wraps_seen >= 2) ? 1 : 0, 1);
    // R8: zero readouts treated as one.
    phase = "R8"; c_reads = 0; wraps_seen = 0; cyc(300);
    chk("R8", "wrap_with_zero_reads", (wraps_seen >= 1) ? 1 : 0, 1);

    // R11: fixed offset loads; out-of-range offset ignored.
    phase = "R11"; scan_en = 0; c_ofs = 5; cyc(60);
    chk("R11", "pos_loaded", int'(pos), 5);
    c_ofs = 14; cyc(60);
    chk("R11", "pos_kept", int'(pos), 5);
    c_ofs = 11; scan_en = 1; c_reads = 1; cyc(80);

    en = 0; cyc(30);
    finished = 1;
    report();
  end
endmodule